// File: doc/BRIEF.md
# Periodic asynchronous status word transmitter

This block builds a fixed-layout 16-bit status word from a handful of field inputs and sends it serially on a single line at a long, fixed repeat interval. The fields are three per-phase DC current-sense alarm flags, six target flags and a two-bit trip release code. A constant marker bit and four zero spare bits fill out the word.

Each frame is an asynchronous character: one low start bit, the 16 data bits least significant first, and one high stop bit. Every bit lasts a whole number of clock cycles, and all line transitions happen on clock edges. Between frames the line rests high (mark). Frames go out only while the enable input is high. The enable signals that initialization has finished. The first frame starts one full period after the enable is first sampled high.

The bit time (`BIT_CYCLES`) and the frame period (`PERIOD_CYCLES`) are parameters counted in clock cycles. The defaults give a 264 ms period at a 125 MHz clock. `PERIOD_CYCLES` must exceed `18*BIT_CYCLES`.

Top module: `status_word_tx`

## Requirements
- R1: Each frame on `tx` is a start bit at 0, then data bits 0 to 15 in that order (least significant first), then a stop bit at 1.
- R2: During reset, and whenever no frame is in progress, `tx` is 1 and `busy` is 0.
- R3: The first frame's start bit begins on the `PERIOD_CYCLES`-th rising edge at which `en` is sampled high. Later frames start exactly `PERIOD_CYCLES` cycles apart while `en` stays high.
- R4: No frame starts while `en` is low. Raising `en` again restarts the period count from zero.
- R5: Word bit 0 is always 1. Bits 1 to 4 are always 0. Bits 5, 6 and 7 carry `dc_alarm[0]`, `dc_alarm[1]` and `dc_alarm[2]` (phases A, B and C), where 1 means the alarm is active.
- R6: Bits 8 to 13 carry `target_on[0]` to `target_on[5]` (targets A1, A2, B1, B2, C1, C2), where 1 means the target is on. Bits 14 and 15 carry `trip_code[0]` and `trip_code[1]`.
- R7: Each of the 18 frame bits lasts exactly `BIT_CYCLES` clocks. `busy` is high for exactly `18*BIT_CYCLES` cycles, starting at the edge that drives the start bit.
- R8: The field inputs are sampled only at the edge that starts a frame. Changes to them during a frame do not alter that frame.
- R9: If `en` falls during a frame, that frame still completes in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | High once initialization has finished; allows periodic frames |
| dc_alarm | input | 3 | Phase A/B/C DC current-sense alarm flags |
| target_on | input | 6 | Target flags A1, A2, B1, B2, C1, C2 |
| trip_code | input | 2 | Trip release code |
| tx | output | 1 | Serial line; idles at 1 |
| busy | output | 1 | High while a frame is on the line |

## Verification
A corrupted shift register shows up within one bit time as a wrong level on `tx` at the middle of some frame bit. A slipped bit counter shows up at the frame's end as a stop bit of the wrong length, or as `busy` dropping at the wrong cycle. An off-by-one in the period counter moves the next start bit by a cycle, and that is visible at the very first frame after enable. The bench checks every bit of every frame, every idle cycle, and the exact start edge of each frame. A fault in any of the three counters therefore appears at the ports within one frame period.

// File: rtl/status_word_tx.sv
module status_word_tx #(
  parameter int BIT_CYCLES    = 13021,
  parameter int PERIOD_CYCLES = 33_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] dc_alarm,
  input  logic [5:0] target_on,
  input  logic [1:0] trip_code,
  output logic       tx,
  output logic       busy
);
  localparam int FRAME_BITS = 18;
  localparam int PW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam int BW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam int NW = $clog2(FRAME_BITS);

  logic [PW-1:0]         per_cnt;
  logic [BW-1:0]         bit_cnt;
  logic [NW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] shreg;

  wire [15:0] word       = {trip_code, target_on, dc_alarm, 4'b0000, 1'b1};
  wire        period_end = en && (per_cnt == PW'(PERIOD_CYCLES - 1));
  wire        bit_end    = (bit_cnt == BW'(BIT_CYCLES - 1));
  wire        last_bit   = (bit_idx == NW'(FRAME_BITS - 1));

  assign tx = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      bit_cnt <= '0;
      bit_idx <= '0;
      busy    <= 1'b0;
      shreg   <= '1;
    end else begin
      if (!en || period_end) per_cnt <= '0;
      else                   per_cnt <= per_cnt + 1'b1;

      if (period_end && !busy) begin
        busy    <= 1'b1;
        shreg   <= {1'b1, word, 1'b0};
        bit_cnt <= '0;
        bit_idx <= '0;
      end else if (busy) begin
        if (bit_end) begin
          bit_cnt <= '0;
          shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
          if (last_bit) busy    <= 1'b0;
          else          bit_idx <= bit_idx + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/status_word_tx_chk.sv
module status_word_tx_chk #(
  parameter int BIT_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tx,
  input logic busy
);
  localparam int FRAME_LEN = 18 * BIT_CYCLES;
  localparam int CW = $clog2(FRAME_LEN + 2);

  logic [CW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx); // R1
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx)); // R1
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(busy)); // R4
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == CW'(FRAME_LEN)); // R7
endmodule

bind status_word_tx status_word_tx_chk #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx(tx), .busy(busy)
);

// File: tb/status_word_tx_tb.sv
`timescale 1ns/1ps
module status_word_tx_tb;
  localparam int BIT = 4;
  localparam int PER = 100;

  logic clk = 1'b0;
  logic rst_n, en;
  logic [2:0] dc_alarm;
  logic [5:0] target_on;
  logic [1:0] trip_code;
  logic tx, busy;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  status_word_tx #(.BIT_CYCLES(BIT), .PERIOD_CYCLES(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dc_alarm(dc_alarm),
    .target_on(target_on), .trip_code(trip_code), .tx(tx), .busy(busy)
  );

  function automatic logic [15:0] exp_word(input logic [2:0] a, input logic [5:0] t, input logic [1:0] c);
    logic [15:0] w;
    w = 16'h0000;
    w[0] = 1'b1;
    for (int i = 0; i < 3; i++) w[5+i] = a[i];
    for (int i = 0; i < 6; i++) w[8+i] = t[i];
    w[14] = c[0];
    w[15] = c[1];
    return w;
  endfunction

  function automatic logic frame_bit(input logic [15:0] w, input int j);
    if (j == 0) return 1'b0;
    if (j == 17) return 1'b1;
    return w[j-1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_fields(input logic [2:0] a, input logic [5:0] t, input logic [1:0] c);
    dc_alarm = a; target_on = t; trip_code = c;
  endtask

  task automatic set_random();
    set_fields(3'($urandom), 6'($urandom), 2'($urandom));
  endtask

  // Called at the negedge right after en is raised; ends just after the start edge.
  task automatic wait_first_start();
    for (int i = 1; i < PER; i++) begin
      @(negedge clk);
      chk(tx == 1'b1 && busy == 1'b0, "R3 idle before first start", {tx, busy}, 2'b10);
    end
    @(negedge clk);
    chk(tx == 1'b0 && busy == 1'b1, "R3 first start edge", {tx, busy}, 2'b01);
  endtask

  // Called just after the start edge; ends just after the frame's last edge.
  task automatic frame(input logic [15:0] w, input bit drop_en);
    for (int j = 0; j < 18; j++) begin
      chk(tx == frame_bit(w, j), (j == 0 || j == 17) ? "R1 start/stop" :
          (j <= 8 ? "R5 low byte bit" : "R6 high byte bit"), tx, frame_bit(w, j));
      if (j > 0) chk(busy == 1'b1, "R9 busy through frame", busy, 1);
      if (j == 2) set_random();   // R8: change fields mid-frame
      if (drop_en && j == 5) en = 1'b0;
      repeat (BIT - 1) @(negedge clk);
      chk(tx == frame_bit(w, j), "R7 bit held for BIT_CYCLES", tx, frame_bit(w, j));
      @(negedge clk);
    end
    chk(busy == 1'b0 && tx == 1'b1, "R7 frame length", {tx, busy}, 2'b10);
  endtask

  // Called after the frame; sets new fields and ends just after the next start edge.
  task automatic to_next(output logic [15:0] w);
    w = exp_word(dc_alarm, target_on, trip_code);
    for (int i = 1; i < PER - 18*BIT; i++) begin
      @(negedge clk);
      chk(tx == 1'b1 && busy == 1'b0, "R2 idle mark", {tx, busy}, 2'b10);
    end
    @(negedge clk);
    chk(tx == 1'b0 && busy == 1'b1, "R3 period start", {tx, busy}, 2'b01);
  endtask

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; en = 1'b0;
    set_fields(3'b000, 6'b0, 2'b00);
    repeat (3) @(negedge clk);
    chk(tx == 1'b1 && busy == 1'b0, "R2 reset state", {tx, busy}, 2'b10);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx == 1'b1 && busy == 1'b0, "R4 no frame while disabled", {tx, busy}, 2'b10);

    en = 1'b1;
    w = exp_word(dc_alarm, target_on, trip_code);
    chk(w == 16'h0001, "R5 all-zero fields word", w, 16'h0001);
    wait_first_start();
    frame(w, 1'b0);

    set_fields(3'b111, 6'b111111, 2'b11);
    to_next(w);
    chk(w == 16'hFFE1, "R6 all-one fields word", w, 16'hFFE1);
    frame(w, 1'b0);

    set_fields(3'b001, 6'b000001, 2'b01);
    to_next(w);
    frame(w, 1'b0);

    for (int k = 0; k < 6; k++) begin
      set_random();
      to_next(w);
      frame(w, 1'b0);
    end

    set_random();
    to_next(w);
    frame(w, 1'b1);  // R9: en drops at bit 5, frame completes

    for (int i = 0; i < 2*PER; i++) begin
      @(negedge clk);
      chk(tx == 1'b1 && busy == 1'b0, "R4 disabled stays idle", {tx, busy}, 2'b10);
    end

    set_random();
    en = 1'b1;
    w = exp_word(dc_alarm, target_on, trip_code);
    wait_first_start();
    frame(w, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule